// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O peripheral for sixteen pads. Software sets a direction per pin and moves output bits only through dedicated set and clear strobe registers, so it never needs a read-modify-write of the output latch. Every pad input passes through a two-flop synchronizer, and the synchronized levels can be read back at any time.

Each pin can also raise an interrupt. A pin is either level-sensitive, with a selectable active level, or edge-sensitive, with separate arm bits for rising and falling edges. Both arm bits may be set at once. Edge events are latched until software clears them by writing ones. Level requests are not latched; they follow the pin. A pin's request reaches the status register only when its mask bit is clear and its enable bit is set. The single interrupt line is the OR of all status bits.

The register interface is a plain single-cycle bus. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from the addressed register.

Top module: `gpio16_irq_ctrl`

## Requirements
- R1: After reset the direction, output latch, level-select, polarity, edge-arm and enable registers read 0 and the mask register reads 0xFFFF. `pad_oe`, `pad_out` and `irq` are 0.
- R2: The direction register (byte offset 0x00, read/write) drives `pad_oe` bit for bit. A 1 makes the pin an output.
- R3: A write to the set strobe (0x04) forces the output bits where the data is 1 high. A write to the clear strobe (0x08) forces them low. Zero data bits leave the other outputs unchanged. The latch appears on `pad_out` and reads back at 0x0C, which ignores writes.
- R4: The input register (0x10, read-only) returns `pad_in` after a two-flop synchronizer. A change applied just after one clock edge becomes readable after the second following edge.
- R5: A pin whose bit is 1 in the level-select register (0x14) requests while its synchronized level matches the polarity register (0x18): 1 means active-high and 0 means active-low. The request is not latched and drops when the pin leaves the active level.
- R6: For a pin in edge mode, a rising edge of the synchronized input with its rising-arm bit (0x1C) set latches an event. The event stays latched after the pin falls.
- R7: For a pin in edge mode, a falling edge with its falling-arm bit (0x20) set latches an event. With both arm bits set, either edge latches.
- R8: Status (0x2C, read-only) shows a pin's request only when its mask bit (0x24) is 0 and its enable bit (0x28) is 1. A latched event held while masked appears once the mask is removed.
- R9: Writing ones to the clear register (0x30) clears those latched edge events and leaves the others latched.
- R10: `irq` is 1 exactly when any status bit is 1.
- R11: Edges on a pin with neither arm bit set, and edges on a level-mode pin, latch nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Byte address; the low two bits are ignored |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Output latch driven to the pads |
| pad_oe | output | 16 | Per-pad output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` are settled before each rising clock edge, and that reset is held for at least one edge before the first access. They also assume that `pad_in` may change at any time, because the synchronizer absorbs it. The stimulus changes bus signals and pads only on the falling clock edge. It holds each pad pattern for several cycles before reading, so every synchronized edge has been latched by the time status is sampled. It writes at most one register per step, so no clear ever coincides with a fresh event.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    parameter int NP     = 16;
    parameter int ADDR_W = 6;
    localparam int WORD_W = ADDR_W - 2;

    typedef logic [NP-1:0] pins_t;

    // word indices (byte offset / 4)
    localparam logic [WORD_W-1:0] W_DIR    = 4'd0;
    localparam logic [WORD_W-1:0] W_SET    = 4'd1;
    localparam logic [WORD_W-1:0] W_CLR    = 4'd2;
    localparam logic [WORD_W-1:0] W_OUT    = 4'd3;
    localparam logic [WORD_W-1:0] W_IN     = 4'd4;
    localparam logic [WORD_W-1:0] W_LVLSEL = 4'd5;
    localparam logic [WORD_W-1:0] W_POL    = 4'd6;
    localparam logic [WORD_W-1:0] W_RISE   = 4'd7;
    localparam logic [WORD_W-1:0] W_FALL   = 4'd8;
    localparam logic [WORD_W-1:0] W_MASK   = 4'd9;
    localparam logic [WORD_W-1:0] W_EN     = 4'd10;
    localparam logic [WORD_W-1:0] W_STAT   = 4'd11;
    localparam logic [WORD_W-1:0] W_ACK    = 4'd12;

    typedef struct packed {
        pins_t dir;
        pins_t out;
        pins_t lvlsel;
        pins_t pol;
        pins_t rise;
        pins_t fall;
        pins_t mask;
        pins_t en;
    } cfg_t;

    typedef struct packed {
        pins_t meta;
        pins_t sync;
        pins_t prev;
    } sync_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pad_i,
    output pins_t level_o,
    output pins_t rise_o,
    output pins_t fall_o
);
    sync_t q, d;

    always_comb begin
        d      = q;
        d.meta = pad_i;
        d.sync = q.meta;
        d.prev = q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level_o = q.sync;
    assign rise_o  = q.sync & ~q.prev;
    assign fall_o  = ~q.sync & q.prev;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word,
    input  pins_t             wdata,
    output cfg_t              cfg_o,
    output pins_t             ack_o
);
    cfg_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            unique case (word)
                W_DIR:    d.dir    = wdata;
                W_SET:    d.out    = q.out | wdata;
                W_CLR:    d.out    = q.out & ~wdata;
                W_LVLSEL: d.lvlsel = wdata;
                W_POL:    d.pol    = wdata;
                W_RISE:   d.rise   = wdata;
                W_FALL:   d.fall   = wdata;
                W_MASK:   d.mask   = wdata;
                W_EN:     d.en     = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mask <= '1;
        end else begin
            q <= d;
        end
    end

    assign cfg_o = q;
    assign ack_o = (wr_en && word == W_ACK) ? wdata : '0;

    // R3: the latch only moves on a strobe write
    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (word == W_SET || word == W_CLR)) |=> $stable(q.out));
    // R3: set strobe raises every selected bit
    assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == W_SET) |=> ((q.out & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
    import gpio_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t level_i,
    input  pins_t rise_i,
    input  pins_t fall_i,
    input  cfg_t  cfg_i,
    input  pins_t ack_i,
    output pins_t status_o
);
    pins_t pend_q, pend_d;
    pins_t evt, lvl_req, raw;

    for (genvar i = 0; i < NP; i++) begin : g_pin
        always_comb begin
            evt[i]     = ~cfg_i.lvlsel[i] &
                         ((rise_i[i] & cfg_i.rise[i]) | (fall_i[i] & cfg_i.fall[i]));
            lvl_req[i] = cfg_i.lvlsel[i] & ~(level_i[i] ^ cfg_i.pol[i]);
            raw[i]     = cfg_i.lvlsel[i] ? lvl_req[i] : pend_q[i];
        end
    end

    always_comb begin
        pend_d = (pend_q & ~ack_i) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign status_o = raw & ~cfg_i.mask & cfg_i.en;

    // R6: every armed edge is latched on the next edge
    assert_edge_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt) & ~pend_q) == '0));
    // R9: acknowledged bits with no new event are gone
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(ack_i & ~evt)) == '0));
endmodule

// File: rtl/gpio16_irq_ctrl.sv
module gpio16_irq_ctrl
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [NP-1:0]     wdata,
    output logic [NP-1:0]     rdata,
    input  logic [NP-1:0]     pad_in,
    output logic [NP-1:0]     pad_out,
    output logic [NP-1:0]     pad_oe,
    output logic              irq
);
    logic [WORD_W-1:0] word;
    cfg_t  cfg;
    pins_t ack, lvl, rise, fall, status;

    assign word = addr[ADDR_W-1:2];

    gpio_sync u_sync (
        .clk(clk), .rst_n(rst_n), .pad_i(pad_in),
        .level_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    gpio_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word(word),
        .wdata(wdata), .cfg_o(cfg), .ack_o(ack)
    );

    gpio_irq u_irq (
        .clk(clk), .rst_n(rst_n), .level_i(lvl), .rise_i(rise),
        .fall_i(fall), .cfg_i(cfg), .ack_i(ack), .status_o(status)
    );

    always_comb begin
        unique case (word)
            W_DIR:    rdata = cfg.dir;
            W_OUT:    rdata = cfg.out;
            W_IN:     rdata = lvl;
            W_LVLSEL: rdata = cfg.lvlsel;
            W_POL:    rdata = cfg.pol;
            W_RISE:   rdata = cfg.rise;
            W_FALL:   rdata = cfg.fall;
            W_MASK:   rdata = cfg.mask;
            W_EN:     rdata = cfg.en;
            W_STAT:   rdata = status;
            default:  rdata = '0;
        endcase
    end

    assign pad_out = cfg.out;
    assign pad_oe  = cfg.dir;
    assign irq     = |status;

    // R8: no status bit without clear mask and set enable
    assert_status_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status & (cfg.mask | ~cfg.en)) == '0);
    // R10: irq line agrees with the status vector
    assert_irq_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (status != '0));
endmodule

// File: tb/sim_gpio16_irq_ctrl.sv
module sim_gpio16_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio16_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // {waddr (FF = none), wdata, pads, raddr, expected, requirement}
    localparam int NV = 26;
    localparam logic [71:0] VEC [NV] = '{
        {8'h00, 16'h00FF, 16'h0000, 8'h00, 16'h00FF, 8'd2},  // R2
        {8'h04, 16'hA5A5, 16'h0000, 8'h0C, 16'hA5A5, 8'd3},  // R3 set
        {8'h08, 16'h0005, 16'h0000, 8'h0C, 16'hA5A0, 8'd3},  // R3 clear
        {8'h04, 16'h0200, 16'h0000, 8'h0C, 16'hA7A0, 8'd3},  // R3 others kept
        {8'hFF, 16'h0000, 16'h1234, 8'h10, 16'h1234, 8'd4},  // R4
        {8'hFF, 16'h0000, 16'h0000, 8'h10, 16'h0000, 8'd4},  // R4
        {8'h28, 16'hFFFF, 16'h0000, 8'h2C, 16'h0000, 8'd11}, // R11 unarmed
        {8'h24, 16'h0000, 16'h0000, 8'h2C, 16'h0000, 8'd11},
        {8'h1C, 16'h000F, 16'h0003, 8'h2C, 16'h0003, 8'd6},  // R6 rise
        {8'hFF, 16'h0000, 16'h0000, 8'h2C, 16'h0003, 8'd6},  // R6 held
        {8'h30, 16'h0001, 16'h0000, 8'h2C, 16'h0002, 8'd9},  // R9 partial
        {8'h20, 16'h00F0, 16'h0030, 8'h2C, 16'h0002, 8'd7},  // R7 rise unarmed
        {8'hFF, 16'h0000, 16'h0000, 8'h2C, 16'h0032, 8'd7},  // R7 fall
        {8'h1C, 16'h00FF, 16'h0040, 8'h2C, 16'h0072, 8'd7},  // R7 both, rise
        {8'hFF, 16'h0000, 16'h0000, 8'h2C, 16'h0072, 8'd7},
        {8'h30, 16'hFFFF, 16'h0000, 8'h2C, 16'h0000, 8'd9},  // R9 all
        {8'h24, 16'h00FF, 16'h0001, 8'h2C, 16'h0000, 8'd8},  // R8 masked
        {8'h24, 16'h0000, 16'h0001, 8'h2C, 16'h0001, 8'd8},  // R8 unmask
        {8'h28, 16'hFFFE, 16'h0001, 8'h2C, 16'h0000, 8'd8},  // R8 disabled
        {8'h28, 16'hFFFF, 16'h0001, 8'h2C, 16'h0001, 8'd8},
        {8'h30, 16'h0001, 16'h0001, 8'h2C, 16'h0000, 8'd9},
        {8'h14, 16'h0300, 16'h0001, 8'h2C, 16'h0300, 8'd5},  // R5 active-low
        {8'h18, 16'h0100, 16'h0001, 8'h2C, 16'h0200, 8'd5},  // R5 polarity
        {8'hFF, 16'h0000, 16'h0101, 8'h2C, 16'h0300, 8'd5},
        {8'hFF, 16'h0000, 16'h0301, 8'h2C, 16'h0100, 8'd5},  // R5 not latched
        {8'h20, 16'h03F0, 16'h0001, 8'h2C, 16'h0200, 8'd11}  // R11 level pins
    };

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a[5:0]; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a[5:0];
        #1 d = rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, v); check(1, v, 16'h0000);
        rd(8'h0C, v); check(1, v, 16'h0000);
        rd(8'h24, v); check(1, v, 16'hFFFF);
        rd(8'h28, v); check(1, v, 16'h0000);
        rd(8'h14, v); check(1, v, 16'h0000);
        check(1, {pad_oe[14:0], irq}, 16'h0000);
        check(1, pad_out, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][71:64] != 8'hFF) wr(VEC[i][71:64], VEC[i][63:48]);
            @(negedge clk);
            pad_in = VEC[i][47:32];
            repeat (5) @(negedge clk);
            rd(VEC[i][31:24], v);
            check(int'(VEC[i][7:0]), v, VEC[i][23:8]);
        end

        // R2 / R3 at the pads
        check(2, pad_oe, 16'h00FF);
        check(3, pad_out, 16'hA7A0);
        wr(8'h0C, 16'h0000);
        rd(8'h0C, v); check(3, v, 16'hA7A0);

        // R10 combined line
        check(10, {15'd0, irq}, 16'h0001);
        wr(8'h28, 16'h0000);
        #1 check(10, {15'd0, irq}, 16'h0000);

        // R4 synchronizer latency
        addr = 6'h10;
        pad_in = 16'h8001;
        @(negedge clk); #1 check(4, rdata, 16'h0001);
        @(negedge clk); #1 check(4, rdata, 16'h8001);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule